// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block is the fetch front end of a small stored-program processor. It holds a program counter, an address staging register, a data capture register and an instruction register. It repeats a fixed, staged sequence that reads one instruction word at a time from word-addressed main memory. Every word travels from the data bus into the capture register and then into the instruction register. The program counter advances in its own step, while the memory read is still outstanding.

The memory side is a single read strobe paired with a word-available return signal. Memory may take any number of cycles to answer. A run input lets the sequencer fetch back to back or park between fetches. A load port sets the program counter while the sequencer is parked at the start of a fetch. Downstream logic sees the instruction register and a one-cycle pulse each time it takes a new word.

Top module: `fetch_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it drops, `ir_word`, `mem_addr`, `mem_rd` and `ir_new` are all zero. The first fetch after reset reads address 0.
- R2: Each fetch drives on `mem_addr` the program counter value sampled at the start of the fetch. `mem_addr` holds steady for as long as `mem_rd` is high.
- R3: `mem_rd` rises in the cycle after the fetch starts. It stays high until `mem_ready` is seen in the wait step, and falls in the cycle after that capture.
- R4: `mem_rdata` is captured only in a wait-step cycle where `mem_ready` is high. A `mem_ready` seen in the two cycles before the wait step has no effect and does not shorten the fetch.
- R5: The captured word reaches `ir_word` one step after capture. `ir_new` is high for exactly that one cycle, and `ir_word` is stable at all other times.
- R6: The program counter advances by one word per fetch and wraps from the highest address to 0.
- R7: With `run` held high, consecutive `ir_new` pulses are 4 + W cycles apart. W = max(1, L − 1), where `mem_ready` comes L cycles after `mem_rd` rises.
- R8: When `run` is low, the sequencer parks only at the start of a fetch. A fetch already under way finishes and delivers its word, and no further read is issued until `run` returns high.
- R9: `pc_load` writes `pc_load_addr` into the program counter only when the sequencer is at the start of a fetch, and there it takes priority over starting a fetch. A `pc_load` at any other step is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High lets a new fetch begin |
| pc_load | input | 1 | Program counter load strobe |
| pc_load_addr | input | ADDR_W | Value written by `pc_load` |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read request |
| mem_rdata | input | WORD_W | Memory read data |
| mem_ready | input | 1 | Memory signals that the requested word is on `mem_rdata` |
| ir_word | output | WORD_W | Instruction register contents |
| ir_new | output | 1 | One-cycle pulse when `ir_word` takes a new word |

## Verification
The bench models memory that answers L cycles after the request, sweeping L from 0 to 5. For each L it checks the spacing of instructions, which shows whether the wait step counts cycles correctly. Outside a ready cycle the model drives a poison word on the data bus, so a capture made without ready, or made too early, appears as a wrong instruction. Separate sequences cover the following:
- parking with `run` low, both at a fetch boundary and in the middle of a handshake;
- a program counter load while parked, and one issued mid-fetch;
- wraparound at the top address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    typedef enum logic [2:0] {
        ST_ADDR = 3'd0,
        ST_REQ  = 3'd1,
        ST_INC  = 3'd2,
        ST_WAIT = 3'd3,
        ST_XFER = 3'd4
    } fetch_step_e;
endpackage

// File: rtl/fetch_pc.sv
module fetch_pc #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              inc,
    output logic [ADDR_W-1:0] pc
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.pc = ld_addr;
        end else if (inc) begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc = st_q.pc;
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mar_ld,
    input  logic [ADDR_W-1:0] pc,
    input  logic              mdr_ld,
    input  logic [WORD_W-1:0] bus_data,
    input  logic              ir_ld,
    output logic [ADDR_W-1:0] mar,
    output logic [WORD_W-1:0] mdr,
    output logic [WORD_W-1:0] ir
);
    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mdr;
        logic [WORD_W-1:0] ir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mar_ld) r_d.mar = pc;
        if (mdr_ld) r_d.mdr = bus_data;
        if (ir_ld)  r_d.ir  = r_q.mdr;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign mar = r_q.mar;
    assign mdr = r_q.mdr;
    assign ir  = r_q.ir;

    assert_ir_from_mdr_R5: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> (r_q.ir == $past(r_q.mdr)));
    assert_ir_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !ir_ld |=> $stable(r_q.ir));
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic pc_load,
    input  logic mem_ready,
    output logic pc_ld,
    output logic pc_inc,
    output logic mar_ld,
    output logic mdr_ld,
    output logic ir_ld,
    output logic rd,
    output logic new_pulse
);
    typedef struct packed {
        fetch_step_e step;
        logic        rd;
        logic        newp;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.newp = 1'b0;
        pc_ld    = 1'b0;
        pc_inc   = 1'b0;
        mar_ld   = 1'b0;
        mdr_ld   = 1'b0;
        ir_ld    = 1'b0;
        case (c_q.step)
            ST_ADDR: begin
                if (pc_load) begin
                    pc_ld = 1'b1;
                end else if (run) begin
                    mar_ld   = 1'b1;
                    c_d.rd   = 1'b1;
                    c_d.step = ST_REQ;
                end
            end
            ST_REQ:  c_d.step = ST_INC;
            ST_INC: begin
                pc_inc   = 1'b1;
                c_d.step = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_ready) begin
                    mdr_ld   = 1'b1;
                    c_d.rd   = 1'b0;
                    c_d.step = ST_XFER;
                end
            end
            ST_XFER: begin
                ir_ld    = 1'b1;
                c_d.newp = 1'b1;
                c_d.step = ST_ADDR;
            end
            default: begin
                c_d.step = ST_ADDR;
                c_d.rd   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.step <= ST_ADDR;
            c_q.rd   <= 1'b0;
            c_q.newp <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd        = c_q.rd;
    assign new_pulse = c_q.newp;

    assert_rd_held_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && !mem_ready) |=> rd);
    assert_drop_after_ready_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rd) |-> $past(mem_ready));
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        new_pulse |=> !new_pulse);
    assert_no_start_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd && !run) |=> !rd);
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_load_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [WORD_W-1:0] ir_word,
    output logic              ir_new
);
    logic              pc_ld, pc_inc, mar_ld, mdr_ld, ir_ld;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] mdr;

    fetch_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .pc_load   (pc_load),
        .mem_ready (mem_ready),
        .pc_ld     (pc_ld),
        .pc_inc    (pc_inc),
        .mar_ld    (mar_ld),
        .mdr_ld    (mdr_ld),
        .ir_ld     (ir_ld),
        .rd        (mem_rd),
        .new_pulse (ir_new)
    );

    fetch_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .ld      (pc_ld),
        .ld_addr (pc_load_addr),
        .inc     (pc_inc),
        .pc      (pc)
    );

    fetch_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .mar_ld   (mar_ld),
        .pc       (pc),
        .mdr_ld   (mdr_ld),
        .bus_data (mem_rdata),
        .ir_ld    (ir_ld),
        .mar      (mem_addr),
        .mdr      (mdr),
        .ir       (ir_word)
    );

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rd || $stable(mem_addr)));
    assert_addr_is_pc_R2: assert property (@(posedge clk) disable iff (rst)
        mar_ld |=> (mem_addr == $past(pc)));
    assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
        pc_inc |=> (pc == $past(pc) + 1'b1));
    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        mdr_ld |=> (mdr == $past(mem_rdata)));
endmodule

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst, run, pc_load, mem_rd, mem_ready, ir_new;
    logic [AW-1:0] pc_load_addr, mem_addr;
    logic [WW-1:0] mem_rdata, ir_word;

    int n_checks = 0;
    int n_fail = 0;
    int lat = 0;
    logic [7:0]    wcnt;
    logic          rd_prev = 1'b0;
    logic          ready_prev = 1'b0;
    logic [AW-1:0] last_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_seq #(.ADDR_W(AW), .WORD_W(WW)) uut (
        .clk(clk), .rst(rst), .run(run), .pc_load(pc_load),
        .pc_load_addr(pc_load_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ir_word(ir_word), .ir_new(ir_new)
    );

    function automatic logic [WW-1:0] word_of(logic [AW-1:0] a);
        return {a, ~a} ^ 16'h3C5A;
    endfunction

    always @(posedge clk) begin
        if (!mem_rd) wcnt <= 8'd0;
        else         wcnt <= wcnt + 8'd1;
    end
    assign mem_ready = mem_rd && (int'(wcnt) >= lat);
    assign mem_rdata = mem_ready ? word_of(mem_addr) : 16'hDEAD;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R3 monitor: request must only drop after ready was seen
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd && !rd_prev) last_addr = mem_addr;
            if (rd_prev && !mem_rd)
                check(ready_prev, "R3", "mem_rd fell without ready", 0, 1);
        end
        rd_prev = mem_rd;
        ready_prev = mem_ready;
    end

    task automatic next_fetch(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!ir_new && cyc < 1000);
        if (cyc >= 1000) check(1'b0, "R5", "timeout waiting ir_new", cyc, 0);
    endtask

    function automatic int period_for(int l);
        return 4 + ((l <= 2) ? 1 : l - 1);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        logic [AW-1:0] exp_a;
        logic [WW-1:0] held;
        bit first;
        rst = 1'b1; run = 1'b0; pc_load = 1'b0; pc_load_addr = '0;
        repeat (3) @(negedge clk);
        check(ir_word == 0 && mem_rd == 0 && mem_addr == 0 && ir_new == 0,
              "R1", "outputs in reset", {ir_word, mem_addr}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ir_word == 0 && mem_rd == 0 && mem_addr == 0 && ir_new == 0,
              "R1", "outputs after reset", {ir_word, mem_addr}, 0);
        run = 1'b1;
        exp_a = '0;
        first = 1'b1;
        // latency sweep: R2 R4 R5 R6 R7
        for (int l = 0; l <= 5; l++) begin
            lat = l;
            for (int k = 0; k < 5; k++) begin
                next_fetch(cyc);
                check(last_addr == exp_a, first ? "R1" : "R2", "fetch address",
                      last_addr, exp_a);
                check(ir_word == word_of(exp_a), "R4", "instruction word",
                      ir_word, word_of(exp_a));
                if (!first)
                    check(cyc == period_for(l), "R7", "fetch period", cyc, period_for(l));
                first = 1'b0;
                exp_a = exp_a + 1'b1;
            end
        end
        @(negedge clk);
        check(ir_new == 1'b0, "R5", "ir_new single cycle", ir_new, 0);
        // boundary park (R8) then load (R9) and wrap (R6)
        lat = 1;
        next_fetch(cyc);
        exp_a = exp_a + 1'b1;
        run = 1'b0;
        held = ir_word;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!mem_rd && !ir_new && ir_word == held, "R8", "parked at boundary",
                  {mem_rd, ir_new}, 0);
        end
        pc_load = 1'b1; pc_load_addr = 8'hFE;
        @(negedge clk);
        pc_load = 1'b0;
        check(!mem_rd, "R9", "load does not start fetch", mem_rd, 0);
        run = 1'b1;
        exp_a = 8'hFE;
        for (int k = 0; k < 4; k++) begin
            next_fetch(cyc);
            check(last_addr == exp_a, "R6", "address after load/wrap", last_addr, exp_a);
            check(ir_word == word_of(exp_a), "R9", "word after load", ir_word, word_of(exp_a));
            exp_a = exp_a + 1'b1;
        end
        // mid-fetch load ignored (R9)
        lat = 5;
        repeat (4) @(negedge clk);
        pc_load = 1'b1; pc_load_addr = 8'h40;
        @(negedge clk);
        pc_load = 1'b0;
        next_fetch(cyc);
        check(last_addr == exp_a, "R9", "mid-fetch load ignored (cur)", last_addr, exp_a);
        exp_a = exp_a + 1'b1;
        next_fetch(cyc);
        check(last_addr == exp_a, "R9", "mid-fetch load ignored (next)", last_addr, exp_a);
        exp_a = exp_a + 1'b1;
        // run drop mid-handshake (R8)
        repeat (3) @(negedge clk);
        check(mem_rd, "R8", "read outstanding at drop", mem_rd, 1);
        run = 1'b0;
        next_fetch(cyc);
        check(ir_word == word_of(exp_a), "R8", "in-flight fetch completes",
              ir_word, word_of(exp_a));
        exp_a = exp_a + 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!mem_rd && !ir_new, "R8", "no read while parked", mem_rd, 0);
        end
        run = 1'b1;
        next_fetch(cyc);
        check(last_addr == exp_a, "R6", "resume address", last_addr, exp_a);
        check(ir_word == word_of(exp_a), "R5", "resume word", ir_word, word_of(exp_a));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule